// File: doc/BRIEF.md
# Delayed Interrupt Coalescer

This block moderates the completion interrupt of a copy engine. Rather than interrupting the host once per finished transfer, it counts receive-done completion pulses and times how long the oldest of them has been waiting. It raises a status bit, and an interrupt line, as soon as either the pending count or the waiting time passes a programmed threshold. Time is measured in ticks of a free-running prescaler. With the default divider setting at a 125 MHz clock, one tick lasts 20 µs.

Software programs the thresholds and a delay-enable bit in a configuration register. It gates the line through an enable register. It acknowledges the event by writing the status value it read back into the status register. Bits written as one are cleared. The same write restarts the pending count and the wait timer. When the delay-enable bit is clear, the block reports every completion at once.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the status (offset 0x220) and enable (offset 0x228) registers read 0, the interrupt line is low, and the configuration register (offset 0x20C) reads 0x0000_9414: delay enabled and both thresholds 20.
- R2: The configuration register holds the delay-enable flag in bit 15, a 7-bit count threshold in bits 14:8 and a 7-bit time threshold in bits 6:0. Writes take effect and read back, and all other bits read 0.
- R3: With delay enabled, the source bit (bit 16) of the status register sets one cycle after the pending completion count becomes greater than the count threshold. Equal to the threshold does not set it.
- R4: With delay enabled, the status bit sets one cycle after the wait time, in ticks counted from the first pending completion, becomes greater than the time threshold. The timer stays at zero while nothing is pending.
- R5: A tick occurs once every TICK_DIV clock cycles, free-running from reset. A time threshold of 0 fires between 2 and TICK_DIV+1 cycles after a single completion.
- R6: With delay disabled (bit 15 clear), every completion sets the status bit at the same clock edge that captures it.
- R7: Writing a one to bit 16 of the status register clears the status bit and restarts both the pending count and the wait timer. Writing zero there leaves status unchanged. A set status bit stays set until acknowledged.
- R8: The interrupt line equals the status bit gated by bit 16 of the enable register. Masking keeps the status bit, and unmasking re-asserts the line if status is still set.
- R9: A completion that arrives in the same cycle as an acknowledge counts as the first pending completion of the new window. With delay disabled, it leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (12) | Register byte offset |
| regWrData | input | DATA_W (32) | Register write data |
| regRdData | output | DATA_W (32) | Read data for regAddr (combinational) |
| doneEvt | input | 1 | One-cycle receive-done completion pulse |
| irqOut | output | 1 | Interrupt line to the host |

## Verification
On every cycle, the assertions check that the status bit holds until acknowledged. They check that an acknowledge clears status and restarts the counter and timer, that a disabled delay turns each completion directly into status, and that a threshold hit always lands in status. They also check that the timer never runs with nothing pending, and that ticks never come back to back. Only the bench scenarios can show the exact cycle where the count and time thresholds fire, the prescaler period range, the masking and unmasking of the line, register readback, and the ordering of a completion that coincides with an acknowledge. The randomized phase compares the line and the status register against a reference model while configuration, enable and acknowledge writes are mixed in.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int THR_W        = 7;
  localparam int CFG_EN_BIT   = 15;
  localparam int CFG_CNT_LSB  = 8;
  localparam int CFG_TIME_LSB = 0;

  typedef struct packed {
    logic             dlyEn;
    logic [THR_W-1:0] cntThr;
    logic [THR_W-1:0] timeThr;
  } coalCfg_t;

  typedef struct packed {
    logic ackPulse;
    logic evtPulse;
  } coalStrobe_t;

  localparam coalCfg_t CFG_RESET = '{dlyEn: 1'b1, cntThr: 7'd20, timeThr: 7'd20};
endpackage

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int TICK_DIV = 2500,
  parameter int CNT_W    = 8,
  parameter int TIME_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  coalStrobe_t strobe,
  input  coalCfg_t    cfg,
  output logic        thrHit
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic              tick;
  logic [CNT_W-1:0]  pendCnt;
  logic [TIME_W-1:0] pendTime;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1))  divCnt <= '0;
        else                                      divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCnt  <= '0;
      pendTime <= '0;
    end else if (strobe.ackPulse) begin
      pendCnt  <= CNT_W'(strobe.evtPulse);
      pendTime <= '0;
    end else begin
      if (strobe.evtPulse && pendCnt != '1)
        pendCnt <= pendCnt + CNT_W'(1);
      if (tick && pendCnt != '0 && pendTime != '1)
        pendTime <= pendTime + TIME_W'(1);
    end
  end

  assign thrHit = cfg.dlyEn &&
                  ((pendCnt > CNT_W'(cfg.cntThr)) ||
                   (pendCnt != '0 && pendTime > TIME_W'(cfg.timeThr)));

  assert_ack_clears_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ackPulse |=> pendTime == '0);

  assert_ack_restarts_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ackPulse |=> pendCnt == CNT_W'($past(strobe.evtPulse)));

  assert_timer_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pendCnt == '0 |-> pendTime == '0);
endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          SRC_BIT  = 16,
  parameter logic [11:0] CFG_OFS  = 12'h20C,
  parameter logic [11:0] STAT_OFS = 12'h220,
  parameter logic [11:0] EN_OFS   = 12'h228
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              doneEvt,
  input  logic              thrHit,
  output coalStrobe_t       strobe,
  output coalCfg_t          cfgQ,
  output logic              irqOut
);
  logic hitCfg, hitStat, hitEn;
  logic enBit, statusBit, setCond, statusNext;
  logic unusedWrBits;

  assign hitCfg  = (regAddr == ADDR_W'(CFG_OFS));
  assign hitStat = (regAddr == ADDR_W'(STAT_OFS));
  assign hitEn   = (regAddr == ADDR_W'(EN_OFS));

  assign strobe.ackPulse = regWr && hitStat && regWrData[SRC_BIT];
  assign strobe.evtPulse = doneEvt;

  assign setCond    = cfgQ.dlyEn ? thrHit : doneEvt;
  assign statusNext = strobe.ackPulse ? (!cfgQ.dlyEn && doneEvt) : (statusBit | setCond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ      <= CFG_RESET;
      enBit     <= 1'b0;
      statusBit <= 1'b0;
    end else begin
      if (regWr && hitCfg)
        cfgQ <= {regWrData[CFG_EN_BIT],
                 regWrData[CFG_CNT_LSB +: THR_W],
                 regWrData[CFG_TIME_LSB +: THR_W]};
      if (regWr && hitEn)
        enBit <= regWrData[SRC_BIT];
      statusBit <= statusNext;
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitCfg) begin
      regRdData[CFG_EN_BIT]              = cfgQ.dlyEn;
      regRdData[CFG_CNT_LSB +: THR_W]    = cfgQ.cntThr;
      regRdData[CFG_TIME_LSB +: THR_W]   = cfgQ.timeThr;
    end else if (hitStat) begin
      regRdData[SRC_BIT] = statusBit;
    end else if (hitEn) begin
      regRdData[SRC_BIT] = enBit;
    end
  end

  assign irqOut       = statusBit & enBit;
  assign unusedWrBits = ^regWrData;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    statusBit && !strobe.ackPulse |=> statusBit);

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ackPulse && !(!cfgQ.dlyEn && doneEvt) |=> !statusBit);

  assert_direct_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgQ.dlyEn && doneEvt |=> statusBit);

  assert_thr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfgQ.dlyEn && thrHit && !strobe.ackPulse |=> statusBit);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import coal_pkg::*;
#(
  parameter int          TICK_DIV = 2500,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          SRC_BIT  = 16,
  parameter int          CNT_W    = 8,
  parameter int          TIME_W   = 8,
  parameter logic [11:0] CFG_OFS  = 12'h20C,
  parameter logic [11:0] STAT_OFS = 12'h220,
  parameter logic [11:0] EN_OFS   = 12'h228
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              doneEvt,
  output logic              irqOut
);
  coalStrobe_t strobe;
  coalCfg_t    cfgQ;
  logic        thrHit;

  coal_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_BIT(SRC_BIT),
    .CFG_OFS(CFG_OFS), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneEvt(doneEvt),
    .thrHit(thrHit), .strobe(strobe), .cfgQ(cfgQ), .irqOut(irqOut)
  );

  coal_datapath #(
    .TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .TIME_W(TIME_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfg(cfgQ), .thrHit(thrHit)
  );
endmodule

// File: tb/irq_coalescer_tb.sv
`timescale 1ns/1ps
module irq_coalescer_tb;
  localparam int DIV = 10;
  localparam logic [11:0] A_CFG = 12'h20C, A_ST = 12'h220, A_EN = 12'h228;

  logic clk = 0, rst_n = 0, regWr = 0, doneEvt = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData, rd;
  logic irqOut;
  int checks = 0, failures = 0, cyc = 0;
  bit chkOn = 0, finished = 0;

  always #4 clk = ~clk;

  irq_coalescer #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneEvt(doneEvt), .irqOut(irqOut)
  );

  // reference model built from the requirements
  logic mEn, mDly, mStat, tk, ak, hit, setc;
  logic [6:0] mCt, mTt;
  logic [7:0] mCnt, mTime;
  int mDiv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mEn <= 0; mDly <= 1; mCt <= 20; mTt <= 20; mStat <= 0;
      mCnt <= 0; mTime <= 0; mDiv <= 0;
    end else begin
      tk   = (mDiv == DIV - 1);
      ak   = regWr && regAddr == A_ST && regWrData[16];
      hit  = mDly && ((mCnt > {1'b0, mCt}) || (mCnt != 0 && mTime > {1'b0, mTt}));
      setc = mDly ? hit : doneEvt;
      mDiv <= tk ? 0 : mDiv + 1;
      mStat <= ak ? (!mDly && doneEvt) : (mStat | setc);
      if (ak) begin
        mCnt <= {7'b0, doneEvt}; mTime <= 0;
      end else begin
        if (doneEvt && mCnt != 8'hFF) mCnt <= mCnt + 1;
        if (tk && mCnt != 0 && mTime != 8'hFF) mTime <= mTime + 1;
      end
      if (regWr && regAddr == A_CFG) begin
        mDly <= regWrData[15]; mCt <= regWrData[14:8]; mTt <= regWrData[6:0];
      end
      if (regWr && regAddr == A_EN) mEn <= regWrData[16];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (chkOn && !finished) check("R8 irq vs model", irqOut, mStat & mEn);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 0;
  endtask
  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regWr = 0; regAddr = a; #1; d = regRdData;
  endtask
  task automatic pulseN(input int n);
    @(negedge clk); doneEvt = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); doneEvt = 0;
  endtask
  task automatic ackWithEvt();
    @(negedge clk); regWr = 1; regAddr = A_ST; regWrData = 32'h1_0000; doneEvt = 1;
    @(negedge clk); regWr = 0; doneEvt = 0;
  endtask
  task automatic measureTick(input string tag);
    int k;
    wrReg(A_ST, 32'h1_0000);
    pulseN(1);
    k = 0;
    while (!irqOut && k < 30) begin @(negedge clk); k++; end
    check(tag, (k >= 2 && k <= DIV + 1), 1);
  endtask

  initial begin
    void'($urandom(32'd20));
    repeat (3) @(negedge clk);
    rst_n = 1; chkOn = 1;
    // R1 reset state
    check("R1 irq", irqOut, 0);
    rdReg(A_CFG, rd); check("R1 cfg", rd, 32'h0000_9414);
    rdReg(A_ST, rd);  check("R1 status", rd, 0);
    rdReg(A_EN, rd);  check("R1 enable", rd, 0);
    // R2 field layout
    wrReg(A_CFG, 32'hFFFF_FFFF); rdReg(A_CFG, rd); check("R2 all ones", rd, 32'h0000_FF7F);
    wrReg(A_CFG, 32'h0000_0A05); rdReg(A_CFG, rd); check("R2 pattern", rd, 32'h0000_0A05);
    wrReg(A_EN, 32'h1_0000); rdReg(A_EN, rd); check("R8 enable readback", rd, 32'h1_0000);
    // R3 count threshold 3
    wrReg(A_CFG, 32'h837F); wrReg(A_ST, 32'h1_0000);
    pulseN(3); repeat (3) @(negedge clk);
    check("R3 equal to threshold", irqOut, 0);
    pulseN(1); check("R3 same cycle", irqOut, 0);
    @(negedge clk); check("R3 fires", irqOut, 1);
    // R8 masking
    wrReg(A_EN, 0); check("R8 masked line", irqOut, 0);
    rdReg(A_ST, rd); check("R8 status kept", rd, 32'h1_0000);
    wrReg(A_EN, 32'h1_0000); check("R8 unmask reasserts", irqOut, 1);
    // R7 write zero, then ack
    wrReg(A_ST, 0); rdReg(A_ST, rd); check("R7 zero write ignored", rd, 32'h1_0000);
    wrReg(A_ST, 32'h1_0000); check("R7 ack clears line", irqOut, 0);
    rdReg(A_ST, rd); check("R7 ack clears status", rd, 0);
    pulseN(3); repeat (3) @(negedge clk);
    check("R7 count restarted", irqOut, 0);
    // R4 time threshold 2
    wrReg(A_CFG, 32'hFF02); wrReg(A_ST, 32'h1_0000);
    pulseN(1); repeat (15) @(negedge clk);
    check("R4 before time", irqOut, 0);
    repeat (20) @(negedge clk);
    check("R4 after time", irqOut, 1);
    // R5 tick period, two phases
    wrReg(A_CFG, 32'hFF00);
    measureTick("R5 tick window a");
    repeat (3) @(negedge clk);
    measureTick("R5 tick window b");
    // R6 delay disabled
    wrReg(A_CFG, 32'h1414); wrReg(A_ST, 32'h1_0000);
    check("R6 idle", irqOut, 0);
    pulseN(1); check("R6 immediate", irqOut, 1);
    // R9 ack coinciding with completion
    wrReg(A_ST, 32'h1_0000); check("R9 cleared", irqOut, 0);
    ackWithEvt(); check("R9 disabled keeps status", irqOut, 1);
    wrReg(A_CFG, 32'h807F); wrReg(A_ST, 32'h1_0000);
    ackWithEvt(); check("R9 enabled same edge", irqOut, 0);
    @(negedge clk); check("R9 counted as first", irqOut, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      doneEvt = ($urandom % 3 == 0);
      r = $urandom % 400;
      regWr = 0;
      if (r < 10) begin
        regWr = 1; regAddr = A_ST; regWrData = 32'h1_0000;
      end else if (r < 12) begin
        regWr = 1; regAddr = A_CFG;
        regWrData = {16'h0, 1'($urandom), 7'($urandom % 8), 1'b0, 7'($urandom % 6)};
      end else if (r < 14) begin
        regWr = 1; regAddr = A_EN; regWrData = {15'h0, 1'($urandom), 16'h0};
      end else if (i % 17 == 0) begin
        regAddr = A_ST; #1;
        check("R3/R4 random status", regRdData, {15'h0, mStat, 16'h0});
      end
    end
    @(negedge clk); regWr = 0; doneEvt = 0;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule